// File: doc/BRIEF.md
# Graphics Controller Register File

This block keeps the nine control registers of a VGA-style graphics controller behind an index port and a data port on a byte-wide host bus. The host writes a register number to the index port, then reads or writes the addressed byte through the data port. The stored bytes are decoded without delay into the control fields the plane datapath needs. These fields are set/reset, its enable, compare colour, colour don't-care, rotate count, logic operation, read plane, write mode, read mode and bit mask.

The block also turns the memory-map field into the base address and size of the host aperture. Two inputs can mark the A and B segments as reserved, and a reserved segment collapses the aperture to size zero. Writes that change mode-relevant bits raise one-cycle notification pulses for the logic around the block. These pulses ask for a display reconfiguration, a remap of the host aperture (which also resets that logic's bank number to zero), or a switch of the read plane.

At reset, the mode and miscellaneous registers load a pair of values picked by a mode-number input. A text-class input settles the pair for modes outside the table.

Top module: `gfx_ctrl_regs`

## Requirements
- R1: While rst_ni is low and after it rises, the index reads 0x00 and registers 0–4 read 0x00. Register 7 reads 0x0F and register 8 reads 0xFF.
- R2: At reset, registers 5 and 6 load values set by mode_i. Modes 0–3 load 0x10 and 0x0E. Modes 4–5 load 0x30 and 0x0F. Mode 6 loads 0x00 and 0x0D. Mode 7 loads 0x10 and 0x0A. Modes 0x0D–0x12 load 0x00 and 0x05. Mode 0x13 loads 0x40 and 0x05. Any other mode loads 0x10 and 0x0E when text_class_i is high, and 0x00 and 0x05 otherwise.
- R3: A write to the index port stores all 8 bits, and idx_o shows them from the next cycle. A data write stores the byte at the index held before that edge, when that index is 0–8. dat_rdata_o always shows the register at the current index.
- R4: When the index is above 8, a data write changes no register and raises no pulse, and dat_rdata_o reads 0x00.
- R5: The fields decode as follows. set_reset_o is reg0[3:0]. ena_sr_o is reg1[3:0]. cmp_color_o is reg2[3:0]. rotate_o is reg3[2:0]. logic_op_o is reg3[4:3]. read_plane_o is reg4[1:0]. write_mode_o is reg5[1:0]. read_mode_o is reg5[3]. cmp_dc_o is reg7[3:0]. bit_mask_o is reg8.
- R6: The map field reg6[3:2] sets the aperture. Value 0 gives base 0xA0000 and size 128 KB. Value 1 gives 0xA0000 and 64 KB. Value 2 gives 0xB0000 and 32 KB. Value 3 gives 0xB8000 and 32 KB.
- R7: When a_rsvd_i is high and the map field is 0 or 1, the aperture is size 0 at base 0xB0000. When b_rsvd_i is high and the map field is 2, the aperture is size 0 at base 0xB8000. Map value 3 ignores both inputs.
- R8: A data write of the byte already stored changes nothing and raises no pulse.
- R9: reconfig_o pulses when a write changes reg5 bits 6:5 or reg6 bit 0.
- R10: remap_o pulses when a write changes reg6 bits 3:2.
- R11: plane_sw_o pulses when a write changes reg4 bits 1:0. A change to any other bit of reg4 raises no pulse.
- R12: Each pulse is high for exactly the one cycle after the write edge. The decoded fields take their new values in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 8 | Mode number used for the reset load |
| text_class_i | input | 1 | Text-class selector for modes outside the table |
| a_rsvd_i | input | 1 | A segment reserved |
| b_rsvd_i | input | 1 | B segment reserved |
| idx_we_i | input | 1 | Index port write strobe |
| dat_we_i | input | 1 | Data port write strobe |
| wdata_i | input | 8 | Write byte for either port |
| idx_o | output | 8 | Current index |
| dat_rdata_o | output | 8 | Register at the current index, 0x00 when out of range |
| set_reset_o | output | 4 | Set/reset value |
| ena_sr_o | output | 4 | Set/reset enable |
| cmp_color_o | output | 4 | Compare colour |
| rotate_o | output | 3 | Rotate count |
| logic_op_o | output | 2 | Logic operation |
| read_plane_o | output | 2 | Read plane |
| write_mode_o | output | 2 | Write mode |
| read_mode_o | output | 1 | Read mode |
| cmp_dc_o | output | 4 | Colour don't-care |
| bit_mask_o | output | 8 | Bit mask |
| win_base_o | output | 20 | Aperture base address |
| win_size_kb_o | output | 8 | Aperture size in KB |
| reconfig_o | output | 1 | Mode reconfigure pulse |
| remap_o | output | 1 | Aperture remap pulse |
| plane_sw_o | output | 1 | Read-plane switch pulse |

## Verification
The hardest case to reach is a write that touches the relevant register but leaves every relevant bit unchanged. Two forms of it matter: rewriting the same byte, and changing only bits outside the watched fields. Both must stay silent while nearby writes pulse. The stimulus covers both forms on purpose. It also runs a pseudo-random write stream whose indices reach past 8 and whose data often repeats the stored byte. It strobes the index and data ports together so that the data lands at the old index. The reset sweep covers table modes, boundary modes and out-of-table modes with both text-class settings. The reserved flags are toggled under every map value.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned NREG = 9;

  localparam int unsigned REG_SR    = 0;
  localparam int unsigned REG_ESR   = 1;
  localparam int unsigned REG_CMP   = 2;
  localparam int unsigned REG_ROT   = 3;
  localparam int unsigned REG_PLANE = 4;
  localparam int unsigned REG_MODE  = 5;
  localparam int unsigned REG_MISC  = 6;
  localparam int unsigned REG_CDC   = 7;
  localparam int unsigned REG_BMASK = 8;

  localparam int unsigned AW = 20;
  localparam int unsigned SW = 8;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [SW-1:0] size_kb;
  } win_t;
endpackage

// File: rtl/gfx_reset_table.sv
module gfx_reset_table
  import gfx_pkg::*;
(
  input  logic [DW-1:0] mode_i,
  input  logic          text_class_i,
  output logic [DW-1:0] mode_rst_o,
  output logic [DW-1:0] misc_rst_o
);
  always_comb begin
    if (mode_i <= 8'h03) begin
      mode_rst_o = 8'h10; misc_rst_o = 8'h0E;
    end else if (mode_i <= 8'h05) begin
      mode_rst_o = 8'h30; misc_rst_o = 8'h0F;
    end else if (mode_i == 8'h06) begin
      mode_rst_o = 8'h00; misc_rst_o = 8'h0D;
    end else if (mode_i == 8'h07) begin
      mode_rst_o = 8'h10; misc_rst_o = 8'h0A;
    end else if (mode_i >= 8'h0D && mode_i <= 8'h12) begin
      mode_rst_o = 8'h00; misc_rst_o = 8'h05;
    end else if (mode_i == 8'h13) begin
      mode_rst_o = 8'h40; misc_rst_o = 8'h05;
    end else if (text_class_i) begin
      mode_rst_o = 8'h10; misc_rst_o = 8'h0E;
    end else begin
      mode_rst_o = 8'h00; misc_rst_o = 8'h05;
    end
  end
endmodule

// File: rtl/gfx_reg_bank.sv
module gfx_reg_bank
  import gfx_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DW-1:0]           mode_rst_i,
  input  logic [DW-1:0]           misc_rst_i,
  input  logic                    idx_we_i,
  input  logic                    dat_we_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           idx_o,
  output logic [DW-1:0]           rdata_o,
  output logic [NREG-1:0][DW-1:0] regs_o,
  output logic                    reconfig_o,
  output logic                    remap_o,
  output logic                    plane_sw_o
);
  logic [DW-1:0]           idx_q;
  logic [NREG-1:0][DW-1:0] regs_q, rst_vals;
  logic [NREG-1:0]         sel;
  logic [DW-1:0]           cur, chg;
  logic                    in_range, wr;
  logic                    reconfig_d, remap_d, plane_d;
  logic                    reconfig_q, remap_q, plane_q;

  always_comb begin
    rst_vals            = '0;
    rst_vals[REG_MODE]  = mode_rst_i;
    rst_vals[REG_MISC]  = misc_rst_i;
    rst_vals[REG_CDC]   = 8'h0F;
    rst_vals[REG_BMASK] = 8'hFF;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign sel[k] = (idx_q == DW'(k));
  end

  assign in_range = (idx_q < DW'(NREG));
  assign wr       = dat_we_i && in_range;

  always_comb begin
    cur = '0;
    for (int k = 0; k < NREG; k++)
      if (sel[k]) cur = regs_q[k];
  end

  // only bits that actually flip can raise an event
  assign chg        = cur ^ wdata_i;
  assign reconfig_d = wr && ((sel[REG_MODE] && |chg[6:5]) || (sel[REG_MISC] && chg[0]));
  assign remap_d    = wr && sel[REG_MISC] && |chg[3:2];
  assign plane_d    = wr && sel[REG_PLANE] && |chg[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      regs_q     <= rst_vals;
      reconfig_q <= 1'b0;
      remap_q    <= 1'b0;
      plane_q    <= 1'b0;
    end else begin
      if (idx_we_i) idx_q <= wdata_i;
      for (int k = 0; k < NREG; k++)
        if (wr && sel[k]) regs_q[k] <= wdata_i;
      reconfig_q <= reconfig_d;
      remap_q    <= remap_d;
      plane_q    <= plane_d;
    end
  end

  assign idx_o      = idx_q;
  assign rdata_o    = cur;
  assign regs_o     = regs_q;
  assign reconfig_o = reconfig_q;
  assign remap_o    = remap_q;
  assign plane_sw_o = plane_q;

  assert_oob_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && !in_range) |=> $stable(regs_q));
  assert_same_value_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && in_range && wdata_i == rdata_o) |=> (!reconfig_q && !remap_q && !plane_q && $stable(regs_q)));
  assert_remap_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(remap_q) |-> $past(dat_we_i) && (regs_q[REG_MISC][3:2] != $past(regs_q[REG_MISC][3:2])));
  assert_plane_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plane_q |-> (regs_q[REG_PLANE][1:0] != $past(regs_q[REG_PLANE][1:0])));
  assert_pulse_needs_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dat_we_i) |-> !(reconfig_q || remap_q || plane_q));
endmodule

// File: rtl/gfx_win_decode.sv
module gfx_win_decode
  import gfx_pkg::*;
(
  input  logic [1:0] map_i,
  input  logic       a_rsvd_i,
  input  logic       b_rsvd_i,
  output win_t       win_o
);
  always_comb begin
    unique case (map_i)
      2'd0: win_o = a_rsvd_i ? '{base: 20'hB0000, size_kb: 8'd0}
                             : '{base: 20'hA0000, size_kb: 8'd128};
      2'd1: win_o = a_rsvd_i ? '{base: 20'hB0000, size_kb: 8'd0}
                             : '{base: 20'hA0000, size_kb: 8'd64};
      2'd2: win_o = b_rsvd_i ? '{base: 20'hB8000, size_kb: 8'd0}
                             : '{base: 20'hB0000, size_kb: 8'd32};
      default: win_o = '{base: 20'hB8000, size_kb: 8'd32};
    endcase
  end

  always_comb begin
    assert_size_legal_R6: assert (win_o.size_kb == 8'd0 || win_o.size_kb == 8'd32 ||
                                  win_o.size_kb == 8'd64 || win_o.size_kb == 8'd128);
  end
endmodule

// File: rtl/gfx_ctrl_regs.sv
module gfx_ctrl_regs
  import gfx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] mode_i,
  input  logic          text_class_i,
  input  logic          a_rsvd_i,
  input  logic          b_rsvd_i,
  input  logic          idx_we_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] idx_o,
  output logic [DW-1:0] dat_rdata_o,
  output logic [3:0]    set_reset_o,
  output logic [3:0]    ena_sr_o,
  output logic [3:0]    cmp_color_o,
  output logic [2:0]    rotate_o,
  output logic [1:0]    logic_op_o,
  output logic [1:0]    read_plane_o,
  output logic [1:0]    write_mode_o,
  output logic          read_mode_o,
  output logic [3:0]    cmp_dc_o,
  output logic [DW-1:0] bit_mask_o,
  output logic [AW-1:0] win_base_o,
  output logic [SW-1:0] win_size_kb_o,
  output logic          reconfig_o,
  output logic          remap_o,
  output logic          plane_sw_o
);
  logic [DW-1:0]           mode_rst, misc_rst;
  logic [NREG-1:0][DW-1:0] regs;
  win_t                    win;

  gfx_reset_table u_rst_tab (
    .mode_i       (mode_i),
    .text_class_i (text_class_i),
    .mode_rst_o   (mode_rst),
    .misc_rst_o   (misc_rst)
  );

  gfx_reg_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_rst_i (mode_rst),
    .misc_rst_i (misc_rst),
    .idx_we_i   (idx_we_i),
    .dat_we_i   (dat_we_i),
    .wdata_i    (wdata_i),
    .idx_o      (idx_o),
    .rdata_o    (dat_rdata_o),
    .regs_o     (regs),
    .reconfig_o (reconfig_o),
    .remap_o    (remap_o),
    .plane_sw_o (plane_sw_o)
  );

  gfx_win_decode u_win (
    .map_i    (regs[REG_MISC][3:2]),
    .a_rsvd_i (a_rsvd_i),
    .b_rsvd_i (b_rsvd_i),
    .win_o    (win)
  );

  assign set_reset_o   = regs[REG_SR][3:0];
  assign ena_sr_o      = regs[REG_ESR][3:0];
  assign cmp_color_o   = regs[REG_CMP][3:0];
  assign rotate_o      = regs[REG_ROT][2:0];
  assign logic_op_o    = regs[REG_ROT][4:3];
  assign read_plane_o  = regs[REG_PLANE][1:0];
  assign write_mode_o  = regs[REG_MODE][1:0];
  assign read_mode_o   = regs[REG_MODE][3];
  assign cmp_dc_o      = regs[REG_CDC][3:0];
  assign bit_mask_o    = regs[REG_BMASK];
  assign win_base_o    = win.base;
  assign win_size_kb_o = win.size_kb;

  assert_rsvd_a_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rsvd_i && !regs[REG_MISC][3]) |-> (win_size_kb_o == 8'd0 && win_base_o == 20'hB0000));
  assert_rsvd_b_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_rsvd_i && regs[REG_MISC][3:2] == 2'd2) |-> (win_size_kb_o == 8'd0 && win_base_o == 20'hB8000));
  assert_reconfig_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconfig_o |-> (regs[REG_MODE][6:5] != $past(regs[REG_MODE][6:5]) ||
                    regs[REG_MISC][0] != $past(regs[REG_MISC][0])));
endmodule

// File: tb/gfx_ctrl_regs_test.sv
module gfx_ctrl_regs_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] mode = 8'h03;
  logic       text_c = 1'b0, a_rsvd = 1'b0, b_rsvd = 1'b0;
  logic       idx_we = 1'b0, dat_we = 1'b0;
  logic [7:0] wdata = 8'h00;

  logic [7:0]  idx_o, rdata_o, bmask_o;
  logic [3:0]  sr_o, esr_o, cmp_o, cdc_o;
  logic [2:0]  rot_o;
  logic [1:0]  lop_o, rplane_o, wmode_o;
  logic        rmode_o, reconfig_o, remap_o, plane_o;
  logic [19:0] base_o;
  logic [7:0]  size_o;

  gfx_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .text_class_i(text_c),
    .a_rsvd_i(a_rsvd), .b_rsvd_i(b_rsvd), .idx_we_i(idx_we), .dat_we_i(dat_we),
    .wdata_i(wdata), .idx_o(idx_o), .dat_rdata_o(rdata_o), .set_reset_o(sr_o),
    .ena_sr_o(esr_o), .cmp_color_o(cmp_o), .rotate_o(rot_o), .logic_op_o(lop_o),
    .read_plane_o(rplane_o), .write_mode_o(wmode_o), .read_mode_o(rmode_o),
    .cmp_dc_o(cdc_o), .bit_mask_o(bmask_o), .win_base_o(base_o), .win_size_kb_o(size_o),
    .reconfig_o(reconfig_o), .remap_o(remap_o), .plane_sw_o(plane_o)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference
  int m_reg[9];
  int m_idx;
  bit e_reconf, e_remap, e_plane;

  function automatic void load_reset(int md, bit tc);
    for (int i = 0; i < 9; i++) m_reg[i] = 0;
    m_reg[7] = 'h0F; m_reg[8] = 'hFF; m_idx = 0;
    if (md <= 3)                    begin m_reg[5] = 'h10; m_reg[6] = 'h0E; end
    else if (md <= 5)               begin m_reg[5] = 'h30; m_reg[6] = 'h0F; end
    else if (md == 6)               begin m_reg[5] = 'h00; m_reg[6] = 'h0D; end
    else if (md == 7)               begin m_reg[5] = 'h10; m_reg[6] = 'h0A; end
    else if (md >= 'h0D && md <= 'h12) begin m_reg[5] = 'h00; m_reg[6] = 'h05; end
    else if (md == 'h13)            begin m_reg[5] = 'h40; m_reg[6] = 'h05; end
    else if (tc)                    begin m_reg[5] = 'h10; m_reg[6] = 'h0E; end
    else                            begin m_reg[5] = 'h00; m_reg[6] = 'h05; end
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      load_reset(int'(mode), text_c);
      e_reconf = 0; e_remap = 0; e_plane = 0;
    end else begin
      int old_idx;
      old_idx = m_idx;
      e_reconf = 0; e_remap = 0; e_plane = 0;
      if (dat_we && old_idx < 9) begin
        int d;
        d = int'(wdata) ^ m_reg[old_idx];
        if (old_idx == 5 && (d & 'h60) != 0) e_reconf = 1;
        if (old_idx == 6 && (d & 'h01) != 0) e_reconf = 1;
        if (old_idx == 6 && (d & 'h0C) != 0) e_remap = 1;
        if (old_idx == 4 && (d & 'h03) != 0) e_plane = 1;
        m_reg[old_idx] = int'(wdata);
      end
      if (idx_we) m_idx = int'(wdata);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int mp, eb, es;
      chk("R3", "index", int'(idx_o), m_idx);
      chk(m_idx < 9 ? "R3" : "R4", "rdata", int'(rdata_o), m_idx < 9 ? m_reg[m_idx] : 0);
      chk("R5", "set_reset", int'(sr_o), m_reg[0] & 'hF);
      chk("R5", "ena_sr", int'(esr_o), m_reg[1] & 'hF);
      chk("R5", "cmp_color", int'(cmp_o), m_reg[2] & 'hF);
      chk("R5", "rotate", int'(rot_o), m_reg[3] & 7);
      chk("R5", "logic_op", int'(lop_o), (m_reg[3] >> 3) & 3);
      chk("R5", "read_plane", int'(rplane_o), m_reg[4] & 3);
      chk("R5", "write_mode", int'(wmode_o), m_reg[5] & 3);
      chk("R5", "read_mode", int'(rmode_o), (m_reg[5] >> 3) & 1);
      chk("R5", "cmp_dc", int'(cdc_o), m_reg[7] & 'hF);
      chk("R5", "bit_mask", int'(bmask_o), m_reg[8]);
      mp = (m_reg[6] >> 2) & 3;
      case (mp)
        0: begin eb = a_rsvd ? 'hB0000 : 'hA0000; es = a_rsvd ? 0 : 128; end
        1: begin eb = a_rsvd ? 'hB0000 : 'hA0000; es = a_rsvd ? 0 : 64; end
        2: begin eb = b_rsvd ? 'hB8000 : 'hB0000; es = b_rsvd ? 0 : 32; end
        default: begin eb = 'hB8000; es = 32; end
      endcase
      chk((a_rsvd || b_rsvd) ? "R7" : "R6", "win_base", int'(base_o), eb);
      chk((a_rsvd || b_rsvd) ? "R7" : "R6", "win_size", int'(size_o), es);
      chk("R9", "reconfig", int'(reconfig_o), int'(e_reconf));
      chk("R10", "remap", int'(remap_o), int'(e_remap));
      chk("R11", "plane_sw", int'(plane_o), int'(e_plane));
    end
  end

  task automatic drive(bit iw, bit dw, logic [7:0] v);
    @(posedge clk); #(PERIOD/4);
    idx_we = iw; dat_we = dw; wdata = v;
    @(posedge clk); #(PERIOD/4);
    idx_we = 0; dat_we = 0;
  endtask

  task automatic wr_reg(logic [7:0] i, logic [7:0] v);
    drive(1, 0, i);
    drive(0, 1, v);
  endtask

  task automatic do_reset(logic [7:0] md, bit tc);
    @(posedge clk); #(PERIOD/4);
    mode = md; text_c = tc; rst_ni = 0;
    repeat (2) @(posedge clk);
    #(PERIOD/4); rst_ni = 1;
    // R1/R2: walk all registers straight after reset
    for (int i = 0; i < 9; i++) drive(1, 0, 8'(i));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    // R1 R2: reset sweep over table and boundary modes
    do_reset(8'h00, 0); do_reset(8'h03, 0); do_reset(8'h04, 0); do_reset(8'h05, 0);
    do_reset(8'h06, 0); do_reset(8'h07, 0); do_reset(8'h08, 1); do_reset(8'h0C, 0);
    do_reset(8'h0D, 1); do_reset(8'h12, 0); do_reset(8'h13, 1); do_reset(8'h14, 1);
    do_reset(8'h14, 0); do_reset(8'hFF, 1);
    do_reset(8'h03, 0);

    // R3 R5: distinct patterns in every register
    for (int i = 0; i < 9; i++) wr_reg(8'(i), 8'hA5 ^ 8'(i * 17));
    for (int i = 0; i < 9; i++) wr_reg(8'(i), 8'h5A + 8'(i));
    // R4: out-of-range index, write and read
    wr_reg(8'h09, 8'h77); wr_reg(8'hFF, 8'h12); wr_reg(8'h10, 8'h00);
    // R8: same-value rewrites
    wr_reg(8'h06, 8'h0C); wr_reg(8'h06, 8'h0C); wr_reg(8'h05, 8'h60); wr_reg(8'h05, 8'h60);
    // R9 R10 R11: targeted and untargeted bit changes
    wr_reg(8'h05, 8'h20); wr_reg(8'h05, 8'h2B); wr_reg(8'h06, 8'h0D); wr_reg(8'h06, 8'h0F);
    wr_reg(8'h06, 8'h03); wr_reg(8'h04, 8'h01); wr_reg(8'h04, 8'hFD); wr_reg(8'h04, 8'hFE);
    // R6 R7: all maps under every reserved combination
    for (int mp = 0; mp < 4; mp++) begin
      wr_reg(8'h06, 8'(mp << 2));
      for (int r = 0; r < 4; r++) begin
        @(posedge clk); #(PERIOD/4);
        a_rsvd = r[0]; b_rsvd = r[1];
        repeat (2) @(posedge clk);
      end
    end
    a_rsvd = 0; b_rsvd = 0;
    // R3: simultaneous index and data strobes use the old index
    drive(1, 0, 8'h08);
    drive(1, 1, 8'h02);
    drive(1, 1, 8'h0B);
    // R12: back-to-back data writes, pulses each cycle then drop
    drive(1, 0, 8'h04);
    @(posedge clk); #(PERIOD/4);
    dat_we = 1; wdata = 8'h01;
    @(posedge clk); #(PERIOD/4); wdata = 8'h02;
    @(posedge clk); #(PERIOD/4); wdata = 8'h02;
    @(posedge clk); #(PERIOD/4); dat_we = 0;
    repeat (2) @(posedge clk);
    // mixed pseudo-random stream
    lfsr = 8'h1D;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      @(posedge clk); #(PERIOD/4);
      idx_we = lfsr[0] & lfsr[3];
      dat_we = lfsr[1];
      a_rsvd = (n % 37) < 9; b_rsvd = (n % 23) < 5;
      wdata = idx_we ? 8'(lfsr % 12) : (lfsr[2] ? 8'(lfsr & 8'h6F) : 8'h0C);
    end
    @(posedge clk); #(PERIOD/4); idx_we = 0; dat_we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule